// File: doc/BRIEF.md
# Bus-Readable Free-Running Timer Counter

This block is a 16-bit up-counter that runs on its own. A fixed divide-by-four prescaler sits in front of it, so the count advances once every four bus clocks and comes back to the same value every 262,144 clocks. Software cannot write the counter. Reset loads it with 0xFFFC, so the first wrap comes a few ticks after reset is released.

Software reads the count one byte at a time over an 8-bit register bus. Two byte-pair windows map onto the same counter, a primary pair and an alternate pair. Reading either high byte freezes the low byte in a holding register. The low-byte read that follows then returns a value that matches the high byte already taken. Further high-byte reads before that low-byte read leave the frozen value alone.

When the count wraps from 0xFFFF to 0x0000, an overflow flag is set. The interrupt request is the flag gated by an enable input. The flag is cleared in two steps: first a status read that sees the flag set, then a high-byte read of the primary pair. Reads of the alternate pair never clear the flag, so software can sample the time without losing an overflow.

Top module: `frc_timer`

## Requirements
- R1: After reset the count is 0xFFFC, the overflow flag is 0, the interrupt request is 0 and no high-byte read is pending, so a low-byte read returns the live value 0xFC.
- R2: The count increments by one on every fourth clock edge after reset, and it wraps modulo 2^16. After n edges the count is (0xFFFC + floor(n/4)) mod 65536.
- R3: A read at address 0x18 (primary high) or 0x1A (alternate high) returns bits 15:8 of the live count. If no read is pending, it also captures bits 7:0 in the holding register and marks a read pending.
- R4: A high-byte read while a read is pending leaves the holding register and the pending mark unchanged.
- R5: A read at address 0x19 (primary low) or 0x1B (alternate low) while a read is pending returns the held byte and clears the pending mark.
- R6: A low-byte read with no read pending returns bits 7:0 of the live count. Reads at any other address return 0x00.
- R7: The overflow flag is set on the clock edge at which the count goes from 0xFFFF to 0x0000.
- R8: The interrupt request is 1 exactly while the overflow flag and the enable input are both 1.
- R9: A status read while the flag is 1 arms a clear. The next read at 0x18 then clears the flag. A status read while the flag is 0 arms nothing.
- R10: Reads at 0x1A or 0x1B never clear the flag, even while a clear is armed.
- R11: If an armed clearing read at 0x18 falls in the same cycle as a wrap, the flag stays 1.
- R12: No read, at any address, changes the count or its stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per byte read |
| rd_addr | input | 8 | Register offset of the read |
| stat_rd | input | 1 | Pulses when software reads the status holding the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| rd_data | output | 8 | Read data, valid in the cycle of the strobe |
| ovf_flag | output | 1 | Overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Some rules can be checked on every cycle, and the assertions do so:
- the count holds or steps by exactly one;
- ticks never come on back-to-back edges;
- a wrap always leaves the flag set;
- the flag falls only after an armed primary high-byte read;
- an alternate read never drops the flag;
- the holding register stays frozen while a read is pending.

Only the bench's scenarios can show the absolute values. These are the 0xFFFC reset start, the exact edge of the first wrap, the bytes returned by mixed read orders against a model of the count, and the race between a wrap and a clearing read. That race is shown on a second instance whose prescaler divides by two, so that a second wrap comes within the run.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_PRI_HI = 8'h18;
  localparam logic [ADDR_W-1:0] A_PRI_LO = 8'h19;
  localparam logic [ADDR_W-1:0] A_ALT_HI = 8'h1A;
  localparam logic [ADDR_W-1:0] A_ALT_LO = 8'h1B;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] upper_of(input logic [CNT_W-1:0] v);
    return v[CNT_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] lower_of(input logic [CNT_W-1:0] v);
    return v[DATA_W-1:0];
  endfunction

  function automatic logic is_high(input logic [ADDR_W-1:0] a);
    return (a == A_PRI_HI) || (a == A_ALT_HI);
  endfunction

  function automatic logic is_low(input logic [ADDR_W-1:0] a);
    return (a == A_PRI_LO) || (a == A_ALT_LO);
  endfunction
endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/frc_count.sv
module frc_count
  import frc_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= RST_VAL;
    else if (tick) cnt <= cnt_next(cnt);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  // R12
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/frc_rdlatch.sv
module frc_rdlatch
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_rd,
  input  logic              lo_rd,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] hold_q;
  logic              pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (hi_rd && !pend_q) begin
      hold_q <= lower_of(cnt);
      pend_q <= 1'b1;
    end else if (lo_rd) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (hi_rd)      rd_data = upper_of(cnt);
    else if (lo_rd) rd_data = pend_q ? hold_q : lower_of(cnt);
  end

  // R4
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hi_rd) |=> ($stable(hold_q) && pend_q));
  // R5
  lo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> !pend_q);
endmodule

// File: rtl/frc_ovf.sv
module frc_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic stat_rd,
  input  logic clr_rd,
  input  logic alt_rd,
  output logic flag
);
  logic armed_q;
  logic clr_hit;

  assign clr_hit = armed_q && clr_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (wrap)         flag <= 1'b1;
      else if (clr_hit) flag <= 1'b0;
      if (clr_hit)               armed_q <= 1'b0;
      else if (stat_rd && flag)  armed_q <= 1'b1;
    end
  end

  // R7
  wrap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag);
  // R9
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed_q && clr_rd));
  // R10
  alt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && alt_rd) |=> flag);
endmodule

// File: rtl/frc_timer.sv
module frc_timer
  import frc_pkg::*;
#(
  parameter int               PRE_DIV = 4,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              stat_rd,
  input  logic              ovf_ie,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_flag,
  output logic              ovf_irq
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt;
  logic             hi_rd;
  logic             lo_rd;
  logic             pri_hi_rd;
  logic             alt_rd;

  assign hi_rd     = rd_en && is_high(rd_addr);
  assign lo_rd     = rd_en && is_low(rd_addr);
  assign pri_hi_rd = rd_en && (rd_addr == A_PRI_HI);
  assign alt_rd    = rd_en && ((rd_addr == A_ALT_HI) || (rd_addr == A_ALT_LO));

  frc_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  frc_count #(.RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .wrap(wrap)
  );

  frc_rdlatch u_rdl (
    .clk(clk), .rst_n(rst_n), .hi_rd(hi_rd), .lo_rd(lo_rd),
    .cnt(cnt), .rd_data(rd_data)
  );

  frc_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .stat_rd(stat_rd),
    .clr_rd(pri_hi_rd), .alt_rd(alt_rd), .flag(ovf_flag)
  );

  assign ovf_irq = ovf_flag && ovf_ie;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_ie |-> !ovf_irq);
  // R12
  read_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !tick) |=> $stable(cnt));
endmodule

// File: tb/frc_timer_tb_top.sv
module frc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic       stat_rd = 1'b0;
  logic       ovf_ie = 1'b0;
  logic [7:0] rd_data;
  logic       ovf_flag, ovf_irq;

  logic       rd_en_s = 1'b0;
  logic [7:0] rd_addr_s = 8'h00;
  logic       stat_rd_s = 1'b0;
  logic [7:0] rd_data_s;
  logic       ovf_flag_s, ovf_irq_s;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wd = 0;
  bit done = 1'b0;

  bit         m_pend = 1'b0;
  logic [7:0] m_hold = 8'h00;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  frc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .stat_rd(stat_rd), .ovf_ie(ovf_ie), .rd_data(rd_data),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
  );

  frc_timer #(.PRE_DIV(2)) dut_s (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en_s), .rd_addr(rd_addr_s),
    .stat_rd(stat_rd_s), .ovf_ie(1'b1), .rd_data(rd_data_s),
    .ovf_flag(ovf_flag_s), .ovf_irq(ovf_irq_s)
  );

  localparam int NV = 12;
  localparam int V_IDLE [NV] = '{0, 1, 3, 2, 5, 0, 7, 1, 4, 2, 0, 6};
  localparam logic [7:0] V_ADDR [NV] =
    '{8'h19, 8'h18, 8'h18, 8'h19, 8'h1B, 8'h1A, 8'h1A, 8'h1B, 8'h19, 8'h30, 8'h18, 8'h19};

  function automatic logic [15:0] model_cnt(input int edges);
    return 16'hFFFC + 16'(edges / 4);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 200000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // called at a negedge; leaves at the next negedge with rd_en low
  task automatic do_read(input logic [7:0] a, input string tag);
    logic [15:0] live;
    logic [7:0]  exp;
    rd_en = 1'b1;
    rd_addr = a;
    #1;
    live = model_cnt(cyc);
    if (a == 8'h18 || a == 8'h1A)      exp = live[15:8];
    else if (a == 8'h19 || a == 8'h1B) exp = m_pend ? m_hold : live[7:0];
    else                               exp = 8'h00;
    chk(tag, {8'h00, rd_data}, {8'h00, exp});
    if ((a == 8'h18 || a == 8'h1A) && !m_pend) begin
      m_pend = 1'b1;
      m_hold = live[7:0];
    end else if (a == 8'h19 || a == 8'h1B) begin
      m_pend = 1'b0;
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 flag", {15'd0, ovf_flag}, 16'd0);
    chk("R1 irq", {15'd0, ovf_irq}, 16'd0);
    // R9: status read with flag clear arms nothing
    pulse_stat();

    // table walk: R3 R4 R5 R6 R12 (first entry R1 live 0xFC)
    for (int i = 0; i < NV; i++) begin
      repeat (V_IDLE[i]) @(negedge clk);
      do_read(V_ADDR[i], "R3/R4/R5/R6/R12 table");
    end

    // R7: first wrap at edge 16
    while (cyc < 20) @(negedge clk);
    #1;
    chk("R7 flag after wrap", {15'd0, ovf_flag}, 16'd1);
    chk("R8 irq disabled", {15'd0, ovf_irq}, 16'd0);
    ovf_ie = 1'b1;
    #1;
    chk("R8 irq enabled", {15'd0, ovf_irq}, 16'd1);
    @(negedge clk);

    // R9: no arming from the earlier status read
    do_read(8'h18, "R9 read unarmed");
    do_read(8'h19, "R5 finish pair");
    chk("R9 flag kept without arming", {15'd0, ovf_flag}, 16'd1);

    // R10: armed, alternate reads keep flag
    pulse_stat();
    do_read(8'h1A, "R10 alt high");
    do_read(8'h1B, "R10 alt low");
    chk("R10 flag kept by alt reads", {15'd0, ovf_flag}, 16'd1);

    // R9: armed primary high read clears
    do_read(8'h18, "R9 clearing read");
    chk("R9 flag cleared", {15'd0, ovf_flag}, 16'd0);
    chk("R8 irq follows flag", {15'd0, ovf_irq}, 16'd0);
    do_read(8'h19, "R5 pair after clear");

    // R4 explicit: repeated high reads spaced apart
    do_read(8'h1A, "R3 capture");
    repeat (9) @(negedge clk);
    do_read(8'h18, "R4 second high");
    repeat (5) @(negedge clk);
    do_read(8'h1B, "R5 buffered low");
    do_read(8'h19, "R6 live low");
    chk("R9 flag stays clear", {15'd0, ovf_flag}, 16'd0);

    // R11 on the divide-by-two instance: wraps at edges 8 and 131080
    while (cyc < 12) @(negedge clk);
    #1;
    chk("R7 second instance flag", {15'd0, ovf_flag_s}, 16'd1);
    stat_rd_s = 1'b1;
    @(negedge clk);
    stat_rd_s = 1'b0;
    while (cyc < 131079) @(negedge clk);
    rd_en_s = 1'b1;
    rd_addr_s = 8'h18;
    #1;
    chk("R11 high byte before wrap", {8'h00, rd_data_s}, 16'h00FF);
    @(negedge clk);
    rd_en_s = 1'b0;
    #1;
    chk("R11 set wins over clear", {15'd0, ovf_flag_s}, 16'd1);
    chk("R8 irq second instance", {15'd0, ovf_irq_s}, 16'd1);

    // R2/R12: the main instance is still on its modelled count
    @(negedge clk);
    do_read(8'h19, "R2 late count low");
    do_read(8'h1A, "R2 late count high");
    do_read(8'h1B, "R5 late pair");

    done = 1'b1;
    finish_run();
  end
endmodule